// File: doc/BRIEF.md
# Synchronous PWM Gate-Drive Generator

This block turns a duty-cycle command into complementary high-side and low-side gate commands for a synchronous step-down power stage. A free-running period counter sets a fixed switching period. By default this is 100 clock ticks, which is 300 kHz from a 30 MHz clock. The duty command gives the high-side on-time in ticks. The block clamps that value between a minimum and a maximum on-time. A programmable dead gap, counted in clock ticks, separates the turn-off of one switch from the turn-on of the other. The gap sits at both edges of every pulse, so the two switches are never on in the same cycle.

Each period runs in a fixed order. It opens with a dead gap of `dt` ticks with both gates low. The high side is then on for the clamped on-time, followed by a second `dt`-tick gap. The low side is on for the rest of the period. The duty and dead-time commands are sampled only at the period boundary, so a pulse is never cut short or stretched by a change made in mid-period.

A protection sequencer drives two override inputs. One forces both switches off. The other forces the high side off and the low side on. The forced low-side turn-on still waits out the dead gap. An override acts on the next clock edge. Releasing it brings back normal switching only at the next period boundary, and that period starts with its leading dead gap.

Top module: `pwm_gate_gen`

## Requirements
- R1: `period_start` pulses high for exactly one cycle every PERIOD (default 100) clock cycles.
- R2: In normal mode, with a duty command inside [MIN_ON, MAX_ON], `gate_hi` is high for exactly that many consecutive cycles in the period.
- R3: A duty command below MIN_ON (default 10) gives an on-time of MIN_ON. A command above MAX_ON (default 91) gives MAX_ON.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: Take the cycle where `period_start` is high as offset 0, and let `dt` be the clamped dead command. `gate_hi` first goes high at offset `dt`. `gate_lo` goes high at offset `on + 2*dt` and stays high to the end of the period. A dead command of 0 is treated as 1, and values above DT_MAX (default 4) are treated as DT_MAX.
- R6: The duty and dead commands are sampled on the edge that raises `period_start`. A change to either input during a period has no effect on that period.
- R7: While `ovr_off` is high, both gates are low from the next cycle on. `ovr_off` takes priority over `ovr_low`.
- R8: While `ovr_low` is high (and `ovr_off` is low), `gate_hi` is low from the next cycle. If `gate_lo` is already high, it stays high. Otherwise it goes high only after `dt` cycles in which both gates have been low.
- R9: After both overrides are released, the override drive holds until the next `period_start`. That period then follows the normal order of R5, starting with both gates low.
- R10: During reset, all outputs are low. The first `period_start` appears on the second clock edge after reset is released, and both gates stay low until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_cmd | input | DUTY_W (7) | Requested high-side on-time in clock ticks |
| dead_cmd | input | DT_W (3) | Requested dead gap in clock ticks |
| ovr_off | input | 1 | Override: both switches off |
| ovr_low | input | 1 | Override: high side off, low side on |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| period_start | output | 1 | One-cycle marker at offset 0 of each period |

## Verification
The bench drives the duty clamp at both limits. It includes a maximum duty with the largest dead gap, which leaves the low side exactly one tick. A design that mishandled this would either overlap the switches or drop the low-side pulse. Dead commands of 0 and above the limit are covered: a missing clamp would leave no gap at all, or squeeze the low side out of the period. A duty change in mid-period must not reshape the running pulse; a design that sampled the command continuously would produce a split or truncated pulse. The override checks look for three faults: a design that switches the low side on in the same cycle the high side drops, one that lets the force-low override beat the both-off override, and one that resumes switching as soon as the override clears instead of at the period boundary.

// File: rtl/pwm_gate_pkg.sv
// Shared types for the PWM gate-drive generator.
// Assumes: included first in compile order.
package pwm_gate_pkg;

    // Drive mode applied to the output stage.
    typedef enum logic [1:0] {
        MODE_RUN = 2'd0,   // normal complementary switching
        MODE_OFF = 2'd1,   // both switches held off
        MODE_LOW = 2'd2    // high side off, low side on
    } drive_mode_e;

endpackage

// File: rtl/pwm_period_ctr.sv
// Free-running switching-period counter.
// Counts 0 .. PERIOD-1 and wraps. Reset value is PERIOD-1, so the first
// edge after reset wraps to 0 and loads the first command set.
// Assumes: PERIOD >= 2.
module pwm_period_ctr #(
    parameter int PERIOD = 100,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    // Marks the final tick of a period.
    assign wrap = (cnt == LAST);

    // Advance the counter and wrap at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= LAST;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt == $past(cnt) + 1'b1)); // R1

endmodule

// File: rtl/pwm_cmd_latch.sv
// Clamps and holds the duty and dead-gap commands for one period.
// The duty is bounded to [MIN_ON, MAX_ON]. A dead command of 0 becomes 1,
// and values above DT_MAX become DT_MAX. Both are loaded only when
// `load` is high (last tick of a period).
// Assumes: MAX_ON + 2*DT_MAX < PERIOD, so a low-side pulse always remains.
module pwm_cmd_latch #(
    parameter int DUTY_W = 7,
    parameter int DT_W   = 3,
    parameter int CNT_W  = 7,
    parameter int MIN_ON = 10,
    parameter int MAX_ON = 91,
    parameter int DT_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]   dead_cmd,
    output logic [CNT_W-1:0]  on_q,
    output logic [DT_W-1:0]   dt_q
);

    localparam logic [DUTY_W-1:0] MIN_D = DUTY_W'(MIN_ON);
    localparam logic [DUTY_W-1:0] MAX_D = DUTY_W'(MAX_ON);
    localparam logic [DT_W-1:0]   DT_HI = DT_W'(DT_MAX);

    logic [CNT_W-1:0] on_c;
    logic [DT_W-1:0]  dt_c;

    // Bound the requested on-time.
    always_comb begin
        if (duty_cmd < MIN_D)      on_c = CNT_W'(MIN_ON);
        else if (duty_cmd > MAX_D) on_c = CNT_W'(MAX_ON);
        else                       on_c = CNT_W'(duty_cmd);
    end

    // Bound the requested dead gap to at least one tick.
    always_comb begin
        if (dead_cmd == '0)        dt_c = DT_W'(1);
        else if (dead_cmd > DT_HI) dt_c = DT_HI;
        else                       dt_c = dead_cmd;
    end

    // Hold the bounded commands for the whole period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= CNT_W'(MIN_ON);
            dt_q <= DT_HI;
        end else if (load) begin
            on_q <= on_c;
            dt_q <= dt_c;
        end
    end

    AST_ON_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q >= CNT_W'(MIN_ON)) && (on_q <= CNT_W'(MAX_ON))); // R3

    AST_DT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_q != '0) && (dt_q <= DT_HI)); // R5

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(on_q) && $stable(dt_q))); // R6

endmodule

// File: rtl/pwm_mode_ctl.sv
// Selects the drive mode from the two override inputs.
// Both-off wins over force-low. Entering an override is immediate. Going
// back to normal switching is allowed only on the cycle that computes
// offset 0 of a period. Reset starts in the both-off mode.
// Assumes: override inputs are synchronous to clk.
module pwm_mode_ctl
    import pwm_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ovr_off,
    input  logic        ovr_low,
    input  logic        at_start,
    output drive_mode_e mode_n,
    output drive_mode_e mode_q
);

    drive_mode_e req;

    // Requested mode by priority.
    always_comb begin
        if (ovr_off)      req = MODE_OFF;
        else if (ovr_low) req = MODE_LOW;
        else              req = MODE_RUN;
    end

    // Apply overrides at once; release only at a period start.
    always_comb begin
        if (req != MODE_RUN)        mode_n = req;
        else if (at_start)          mode_n = MODE_RUN;
        else                        mode_n = mode_q;
    end

    // Remember the mode in force.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_n;
    end

    AST_RELEASE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q != MODE_RUN) && (mode_n == MODE_RUN)) |-> at_start); // R9

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_off |=> (mode_q == MODE_OFF)); // R7

endmodule

// File: rtl/pwm_gate_drv.sv
// Output stage: turns the period position, the held commands and the mode
// into registered gate commands.
// Normal schedule by offset c: gap [0,dt), high [dt,dt+on), gap, low from
// on+2*dt. A gap guard lets either gate rise only after dt cycles with
// both gates low. This covers schedule edges and override entries alike.
// Assumes: on and dt are already bounded.
module pwm_gate_drv
    import pwm_gate_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DT_W   = 3,
    parameter int PERIOD = 100,
    parameter int MIN_ON = 10,
    parameter int MAX_ON = 91
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] on_q,
    input  logic [DT_W-1:0]  dt_q,
    input  drive_mode_e      mode_n,
    input  drive_mode_e      mode_q,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             period_start
);

    localparam int WW = CNT_W + 2;

    logic [WW-1:0]   c_w, t_w, on_w;
    logic            hi_want, lo_want, gap_ok;
    logic            hi_n, lo_n;
    logic [DT_W-1:0] gap_cnt;

    assign c_w  = WW'(cnt);
    assign t_w  = WW'(dt_q);
    assign on_w = WW'(on_q);

    // Schedule windows within the period.
    assign hi_want = (c_w >= t_w) && (c_w < t_w + on_w);
    assign lo_want = (c_w >= on_w + (t_w << 1));

    // A switch may turn on only after a full gap with both off.
    assign gap_ok = !gate_hi && !gate_lo && (gap_cnt >= dt_q);

    // Next gate values per mode.
    always_comb begin
        hi_n = 1'b0;
        lo_n = 1'b0;
        case (mode_n)
            MODE_RUN: begin
                hi_n = hi_want && (gate_hi || gap_ok);
                lo_n = lo_want && (gate_lo || gap_ok);
            end
            MODE_LOW: lo_n = gate_lo || gap_ok;
            default: ;
        endcase
    end

    // Register the gates and the period marker together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi      <= 1'b0;
            gate_lo      <= 1'b0;
            period_start <= 1'b0;
        end else begin
            gate_hi      <= hi_n;
            gate_lo      <= lo_n;
            period_start <= (cnt == '0);
        end
    end

    // Count consecutive cycles with both gates low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_cnt <= '0;
        else if (hi_n || lo_n)     gap_cnt <= '0;
        else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
    end

    // Length of the current high-side pulse, for the on-time checks.
    logic [CNT_W:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_run <= '0;
        else if (!hi_n)                      hi_run <= '0;
        else if (hi_run != (CNT_W+1)'(PERIOD)) hi_run <= hi_run + 1'b1;
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R4

    AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> $past(!gate_lo)); // R5

    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> $past(!gate_hi)); // R5

    AST_HI_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= (CNT_W+1)'(MAX_ON)); // R2

    AST_HI_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_hi) && (mode_q == MODE_RUN)) |-> ($past(hi_run) >= (CNT_W+1)'(MIN_ON))); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> (!gate_hi && !gate_lo)); // R7

    AST_LOW_NO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOW) |-> !gate_hi); // R8

endmodule

// File: rtl/pwm_gate_gen.sv
// Synchronous PWM gate-drive generator, top level.
// Wires the period counter, command holder, mode control and output stage.
// Assumes: all inputs synchronous to clk; MAX_ON + 2*DT_MAX < PERIOD.
module pwm_gate_gen
    import pwm_gate_pkg::*;
#(
    parameter int PERIOD = 100,
    parameter int MIN_ON = 10,
    parameter int MAX_ON = 91,
    parameter int DT_MAX = 4,
    parameter int DUTY_W = 7,
    parameter int DT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]   dead_cmd,
    input  logic              ovr_off,
    input  logic              ovr_low,
    output logic              gate_hi,
    output logic              gate_lo,
    output logic              period_start
);

    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] on_q;
    logic [DT_W-1:0]  dt_q;
    drive_mode_e      mode_n, mode_q;
    logic             at_start;

    // Offset 0 of the period is being computed this cycle.
    assign at_start = (cnt == '0);

    pwm_period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap)
    );

    pwm_cmd_latch #(
        .DUTY_W(DUTY_W), .DT_W(DT_W), .CNT_W(CNT_W),
        .MIN_ON(MIN_ON), .MAX_ON(MAX_ON), .DT_MAX(DT_MAX)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .load(wrap),
        .duty_cmd(duty_cmd), .dead_cmd(dead_cmd),
        .on_q(on_q), .dt_q(dt_q)
    );

    pwm_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .ovr_off(ovr_off), .ovr_low(ovr_low),
        .at_start(at_start), .mode_n(mode_n), .mode_q(mode_q)
    );

    pwm_gate_drv #(
        .CNT_W(CNT_W), .DT_W(DT_W), .PERIOD(PERIOD),
        .MIN_ON(MIN_ON), .MAX_ON(MAX_ON)
    ) u_drv (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .on_q(on_q), .dt_q(dt_q),
        .mode_n(mode_n), .mode_q(mode_q),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start)
    );

    AST_OFF_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_off |=> (!gate_hi && !gate_lo)); // R7

    AST_LOW_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_low && !ovr_off) |=> !gate_hi); // R8

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start); // R1

endmodule

// File: tb/sim_pwm_gate_gen.sv
// Scoreboard bench: the driver pushes the expected shape of each period,
// and a monitor measures every period and compares.
module sim_pwm_gate_gen;

    localparam int P     = 100;
    localparam int MINON = 10;
    localparam int MAXON = 91;
    localparam int DTMAX = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] duty_cmd = 7'd50;
    logic [2:0] dead_cmd = 3'd1;
    logic       ovr_off = 1'b0;
    logic       ovr_low = 1'b0;
    logic       gate_hi, gate_lo, period_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_gate_gen u0 (
        .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .dead_cmd(dead_cmd),
        .ovr_off(ovr_off), .ovr_low(ovr_low),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start)
    );

    typedef struct {
        int    idx;
        int    plen;
        int    hf;
        int    hl;
        int    lf;
        int    ll;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int clamp_on(input int d);
        if (d < MINON) return MINON;
        if (d > MAXON) return MAXON;
        return d;
    endfunction

    function automatic int clamp_dt(input int t);
        if (t == 0) return 1;
        if (t > DTMAX) return DTMAX;
        return t;
    endfunction

    // Monitor: measure each period between period_start pulses.
    int mon_idx = 0;
    bit have = 1'b0;
    int off, m_hf, m_hl, m_lf, m_ll;
    bit ovl;

    task automatic finalize();
        exp_t e;
        chk(!ovl, "R4", "overlap in period", int'(ovl), 0);
        if (exp_q.size() > 0 && exp_q[0].idx == mon_idx) begin
            e = exp_q.pop_front();
            chk(off == e.plen, "R1", {e.tag, " period length"}, off, e.plen);
            chk(m_hf == e.hf, "R5", {e.tag, " high first offset"}, m_hf, e.hf);
            chk(m_hl == e.hl, e.tag, "high on-time", m_hl, e.hl);
            chk(m_lf == e.lf, "R5", {e.tag, " low first offset"}, m_lf, e.lf);
            chk(m_ll == e.ll, "R5", {e.tag, " low on-time"}, m_ll, e.ll);
        end
    endtask

    always @(negedge clk) begin
        if (period_start === 1'b1) begin
            if (have) finalize();
            have = 1'b1;
            mon_idx++;
            off = 0; m_hf = -1; m_hl = 0; m_lf = -1; m_ll = 0; ovl = 1'b0;
        end
        if (have) begin
            if (gate_hi) begin if (m_hf < 0) m_hf = off; m_hl++; end
            if (gate_lo) begin if (m_lf < 0) m_lf = off; m_ll++; end
            if (gate_hi && gate_lo) ovl = 1'b1;
            off++;
        end
    end

    // Wait for a period_start, then step past the monitor update.
    task automatic wait_start();
        @(negedge clk);
        while (period_start !== 1'b1) @(negedge clk);
        #1;
    endtask

    // Driver: set commands for the next period and push its expected shape.
    task automatic sched(input int d, input int t, input string tag);
        exp_t e;
        int on, dt;
        wait_start();
        duty_cmd = 7'(d);
        dead_cmd = 3'(t);
        on = clamp_on(d);
        dt = clamp_dt(t);
        e.idx = mon_idx + 1; e.plen = P; e.hf = dt; e.hl = on;
        e.lf = on + 2*dt; e.ll = P - on - 2*dt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual 1 expected 0");
            finish_up();
        end
    end

    initial begin
        exp_t e;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!gate_hi && !gate_lo && !period_start, "R10", "outputs in reset",
            {29'd0, gate_hi, gate_lo, period_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!period_start && !gate_hi && !gate_lo, "R10", "first edge after reset",
            {29'd0, gate_hi, gate_lo, period_start}, 0);
        @(negedge clk);
        chk(period_start === 1'b1, "R10", "first period_start on second edge",
            int'(period_start), 1);

        // Normal shapes through the scoreboard.
        sched(50, 1, "R2");
        sched(50, 3, "R2");
        sched(5, 2, "R3");      // below minimum -> 10
        sched(120, 4, "R3");    // above maximum -> 91, one low tick left
        sched(0, 0, "R3");      // dead 0 -> 1
        sched(40, 7, "R2");     // dead 7 -> 4
        sched(91, 2, "R2");
        sched(10, 1, "R3");
        // R6: change in mid-period does not affect the running period
        sched(30, 1, "R6");
        wait_start();
        repeat (20) @(negedge clk);
        duty_cmd = 7'd70;
        e.idx = mon_idx + 1; e.plen = P; e.hf = 1; e.hl = 70;
        e.lf = 72; e.ll = P - 72; e.tag = "R6";
        exp_q.push_back(e);
        wait_start();
        wait_start();
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

        // Force-low override in mid-pulse (duty 50, dead 2).
        wait_start();
        duty_cmd = 7'd50;
        dead_cmd = 3'd2;
        wait_start();
        repeat (10) @(negedge clk);
        chk(gate_hi === 1'b1, "R2", "high side on at offset 10", int'(gate_hi), 1);
        ovr_low = 1'b1;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R8", "force-low drops high, gap",
            {30'd0, gate_hi, gate_lo}, 0);
        @(negedge clk);
        chk(!gate_lo, "R8", "low waits second gap tick", int'(gate_lo), 0);
        @(negedge clk);
        chk(gate_lo === 1'b1 && !gate_hi, "R8", "low on after gap", int'(gate_lo), 1);

        // Both-off wins over force-low.
        ovr_off = 1'b1;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R7", "both off over force-low",
            {30'd0, gate_hi, gate_lo}, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                if (gate_hi || gate_lo) bad++;
            end
            chk(bad == 0, "R7", "both off held for 150 cycles", bad, 0);
        end
        ovr_off = 1'b0;
        repeat (5) @(negedge clk);
        chk(gate_lo === 1'b1 && !gate_hi, "R8", "force-low after both-off clears",
            int'(gate_lo), 1);

        // R9: release waits for the period boundary.
        wait_start();
        repeat (5) @(negedge clk);
        ovr_low = 1'b0;
        @(negedge clk);
        chk(gate_lo === 1'b1 && !gate_hi, "R9", "low held until boundary",
            int'(gate_lo), 1);
        @(negedge clk);
        while (period_start !== 1'b1) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R9", "both low at period start",
            {30'd0, gate_hi, gate_lo}, 0);
        @(negedge clk);
        chk(!gate_hi, "R9", "high still off at offset 1", int'(gate_hi), 0);
        @(negedge clk);
        chk(gate_hi === 1'b1 && !gate_lo, "R9", "high on at offset dt=2",
            int'(gate_hi), 1);

        // Both-off during the low-side window.
        repeat (68) @(negedge clk);   // offset 70
        chk(gate_lo === 1'b1, "R5", "low on at offset 70", int'(gate_lo), 1);
        ovr_off = 1'b1;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R7", "both off from low window",
            {30'd0, gate_hi, gate_lo}, 0);
        ovr_off = 1'b0;
        wait_start();
        wait_start();

        done = 1'b1;
        finish_up();
    end

endmodule